// File: doc/BRIEF.md
# Shared-RAM Message Buffer Manager

This block sits between the word-level front end of a serial-bus remote terminal and a 1K x 16 single-port RAM that the terminal shares with its host. For every command the front end accepts, the manager looks up a 16-bit buffer pointer for that subaddress or mode code. The pointers live in the top 64 words of the RAM, at 0x3C0 to 0x3FF. The manager stores the command word at the address the pointer holds. It then either stores the incoming data words behind it or reads the outgoing data words from behind it and hands them to the transmitter. When the message ends cleanly, it writes the pointer back, advanced past the message.

A pointer has two fields. Bits 9:0 hold the buffer address and bits 15:10 hold a count of the messages still allowed. Each completed message decrements the count and moves the address on by the number of words stored. Once the count is zero, the pointer is no longer changed, so each later message lands in the last buffer and overwrites it. The host fills the pointer table and the message areas, and it reads the results through its own port, which is arbitrated outside this block.

The controller is one state machine. Its states are ST_IDLE, ST_PTR_RD, ST_PTR_WAIT, ST_CMD_WR, ST_RX_DATA, ST_TX_RD, ST_TX_OUT, ST_WAIT_END and ST_PTR_WR. Its transitions are:
- ST_IDLE to ST_PTR_RD on an accepted command that has a pointer.
- ST_PTR_RD to ST_PTR_WAIT, then ST_PTR_WAIT to ST_CMD_WR.
- ST_CMD_WR to ST_WAIT_END when no data words move. Otherwise to ST_RX_DATA for a receive, or to ST_TX_RD for a transmit.
- ST_RX_DATA to ST_WAIT_END on the last data word.
- ST_TX_RD to ST_TX_OUT. ST_TX_OUT goes back to ST_TX_RD, or to ST_WAIT_END after the last word.
- ST_WAIT_END to ST_PTR_WR on a clean end, and ST_PTR_WR to ST_IDLE.
- An abort in any state other than ST_IDLE and ST_PTR_WR returns to ST_IDLE.

Top module: `msgbuf_mgr`

## Requirements
- R1: While reset is held and after it is released, with no command given, ram_en and tx_valid are 0.
- R2: The command word has this layout: bit 10 is the direction (1 = transmit), bits 9:5 are the subaddress, and bits 4:0 are the word count or mode code. For subaddresses 1 to 30, the pointer of a receive command is at 0x3C0 + subaddress and the pointer of a transmit command is at 0x3E0 + subaddress.
- R3: Subaddresses 0 and 31 carry mode codes. Four mode codes have pointers: transmit code 16 uses 0x3C0 and sends one word; receive code 17 uses 0x3DF and stores one word; transmit code 18 uses 0x3E0 and stores only the command word; transmit code 19 uses 0x3FF and sends one word. Every other mode command makes no RAM access.
- R4: The command word is written at the pointer address. Received data words are written at the following addresses, in the order they arrive.
- R5: For a transmit, data words are read from the addresses following the command word. They are presented in order on tx_word, each with a one-cycle tx_valid.
- R6: A word count field of 0 means 32 data words.
- R7: On msg_ok, if the pointer index is not zero, the pointer is rewritten with the index minus 1 and the address plus the number of words stored, wrapping at 10 bits.
- R8: If the pointer index is zero, the pointer is rewritten unchanged, and the next message for that pointer overwrites the same buffer.
- R9: If sys_busy is high when a command is accepted, only the command word is stored. No data word is stored or read, and the pointer advances by one word.
- R10: A msg_err before the pointer write-back ends the message with the pointer unchanged.
- R11: A last-command pointer of 0xFC00 becomes 0xF801 after one store and 0x003F after 63 stores, and it keeps that value after further stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe of an accepted command |
| cmd_word | input | 16 | Command word |
| sys_busy | input | 1 | Busy option, sampled with the command |
| rx_valid | input | 1 | Strobe of a received data word |
| rx_word | input | 16 | Received data word |
| msg_ok | input | 1 | Message completed without error |
| msg_err | input | 1 | Message aborted |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 10 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after the read |
| tx_valid | output | 1 | Transmit word valid |
| tx_word | output | 16 | Transmit data word |

## Verification
The bench goes after the following corner cases:
- The message that finds the index already at zero. A design that keeps advancing would spill into the next buffer instead of overwriting the last one.
- A word count of 0. A design that takes 0 literally would store nothing.
- Wrap-around of the 32-word buffer address.
- The four mode codes that carry data, next to mode codes that must leave the RAM untouched. A wrong decode writes a pointer slot that belongs to a subaddress.
- Busy commands and aborted messages. Here a wrong design would store data it must drop, or advance a pointer it must leave as it was.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PTR_RD,
        ST_PTR_WAIT,
        ST_CMD_WR,
        ST_RX_DATA,
        ST_TX_RD,
        ST_TX_OUT,
        ST_WAIT_END,
        ST_PTR_WR
    } mgr_state_t;

    // Size of the pointer table at the top of the RAM; half of it is receive side.
    localparam int PTR_REGION_WORDS = 64;
    localparam int SA_HALF          = PTR_REGION_WORDS / 2;
    localparam int MAX_WORDS        = 32;

    // Mode codes that own a pointer slot.
    localparam logic [4:0] MC_TX_VECTOR  = 5'd16;
    localparam logic [4:0] MC_RX_SYNC    = 5'd17;
    localparam logic [4:0] MC_TX_LASTCMD = 5'd18;
    localparam logic [4:0] MC_TX_BIT     = 5'd19;

endpackage

// File: rtl/msgbuf_decode.sv
module msgbuf_decode
    import msgbuf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 6
) (
    input  logic [10:0]       cmd_bits,
    output logic              mapped,
    output logic              is_tx,
    output logic [ADDR_W-1:0] ptr_loc,
    output logic [CNT_W-1:0]  n_data
);
    localparam logic [ADDR_W-1:0] PTR_BASE = ADDR_W'((1 << ADDR_W) - PTR_REGION_WORDS);
    localparam logic [ADDR_W-1:0] OFS_VECTOR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_SYNC   = ADDR_W'(SA_HALF - 1);
    localparam logic [ADDR_W-1:0] OFS_LAST   = ADDR_W'(SA_HALF);
    localparam logic [ADDR_W-1:0] OFS_BIT    = ADDR_W'(PTR_REGION_WORDS - 1);

    logic [4:0] sa;
    logic [4:0] fld;
    logic       mode_cmd;

    assign is_tx    = cmd_bits[10];
    assign sa       = cmd_bits[9:5];
    assign fld      = cmd_bits[4:0];
    assign mode_cmd = (sa == 5'd0) || (sa == 5'd31);

    always_comb begin
        mapped  = 1'b0;
        ptr_loc = PTR_BASE;
        n_data  = '0;
        if (!mode_cmd) begin
            mapped  = 1'b1;
            ptr_loc = PTR_BASE + (is_tx ? ADDR_W'(SA_HALF) : ADDR_W'(0)) + ADDR_W'(sa);
            n_data  = (fld == 5'd0) ? CNT_W'(MAX_WORDS) : CNT_W'(fld);
        end else if (is_tx && fld == MC_TX_VECTOR) begin
            mapped  = 1'b1;
            ptr_loc = PTR_BASE + OFS_VECTOR;
            n_data  = CNT_W'(1);
        end else if (!is_tx && fld == MC_RX_SYNC) begin
            mapped  = 1'b1;
            ptr_loc = PTR_BASE + OFS_SYNC;
            n_data  = CNT_W'(1);
        end else if (is_tx && fld == MC_TX_LASTCMD) begin
            mapped  = 1'b1;
            ptr_loc = PTR_BASE + OFS_LAST;
            n_data  = '0;
        end else if (is_tx && fld == MC_TX_BIT) begin
            mapped  = 1'b1;
            ptr_loc = PTR_BASE + OFS_BIT;
            n_data  = CNT_W'(1);
        end
    end

endmodule

// File: rtl/msgbuf_ptr_next.sv
module msgbuf_ptr_next #(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 6,
    parameter int STEP_W = 7
) (
    input  logic [IDX_W+ADDR_W-1:0] cur,
    input  logic [STEP_W-1:0]       step,
    output logic [IDX_W+ADDR_W-1:0] nxt
);
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;

    assign idx  = cur[IDX_W+ADDR_W-1:ADDR_W];
    assign addr = cur[ADDR_W-1:0];

    // A spent index freezes the pointer so the last buffer is reused.
    always_comb begin
        if (idx == '0) begin
            nxt = cur;
        end else begin
            nxt = {idx - IDX_W'(1), addr + ADDR_W'(step)};
        end
    end

endmodule

// File: rtl/msgbuf_mgr.sv
module msgbuf_mgr
    import msgbuf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [IDX_W+ADDR_W-1:0] cmd_word,
    input  logic                    sys_busy,
    input  logic                    rx_valid,
    input  logic [IDX_W+ADDR_W-1:0] rx_word,
    input  logic                    msg_ok,
    input  logic                    msg_err,
    output logic                    ram_en,
    output logic                    ram_we,
    output logic [ADDR_W-1:0]       ram_addr,
    output logic [IDX_W+ADDR_W-1:0] ram_wdata,
    input  logic [IDX_W+ADDR_W-1:0] ram_rdata,
    output logic                    tx_valid,
    output logic [IDX_W+ADDR_W-1:0] tx_word
);
    localparam int WORD_W = IDX_W + ADDR_W;
    localparam int CNT_W  = $clog2(MAX_WORDS) + 1;
    localparam int STEP_W = CNT_W + 1;

    mgr_state_t        state_q, state_d;
    logic [WORD_W-1:0] cmd_q;
    logic [WORD_W-1:0] ptr_q;
    logic [ADDR_W-1:0] loc_q;
    logic              is_tx_q;
    logic              busy_q;
    logic [CNT_W-1:0]  ndat_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              dec_mapped;
    logic              dec_tx;
    logic [ADDR_W-1:0] dec_loc;
    logic [CNT_W-1:0]  dec_n;
    logic [WORD_W-1:0] ptr_upd;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] data_addr;
    logic              last_word;

    msgbuf_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) decode_i (
        .cmd_bits (cmd_word[10:0]),
        .mapped   (dec_mapped),
        .is_tx    (dec_tx),
        .ptr_loc  (dec_loc),
        .n_data   (dec_n)
    );

    assign step = STEP_W'(ndat_q) + STEP_W'(1);

    msgbuf_ptr_next #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .STEP_W(STEP_W)) next_i (
        .cur  (ptr_q),
        .step (step),
        .nxt  (ptr_upd)
    );

    assign data_addr = ptr_q[ADDR_W-1:0] + ADDR_W'(cnt_q) + ADDR_W'(1);
    assign last_word = (cnt_q == ndat_q - CNT_W'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid && dec_mapped) state_d = ST_PTR_RD;
            ST_PTR_RD:   state_d = ST_PTR_WAIT;
            ST_PTR_WAIT: state_d = ST_CMD_WR;
            ST_CMD_WR: begin
                if (ndat_q == '0)  state_d = ST_WAIT_END;
                else if (is_tx_q)  state_d = ST_TX_RD;
                else               state_d = ST_RX_DATA;
            end
            ST_RX_DATA:  if (rx_valid && last_word) state_d = ST_WAIT_END;
            ST_TX_RD:    state_d = ST_TX_OUT;
            ST_TX_OUT:   state_d = last_word ? ST_WAIT_END : ST_TX_RD;
            ST_WAIT_END: if (msg_ok) state_d = ST_PTR_WR;
            ST_PTR_WR:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (msg_err && state_q != ST_IDLE && state_q != ST_PTR_WR) begin
            state_d = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Message context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            ptr_q   <= '0;
            loc_q   <= '0;
            is_tx_q <= 1'b0;
            busy_q  <= 1'b0;
            ndat_q  <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid && dec_mapped) begin
                        cmd_q   <= cmd_word;
                        loc_q   <= dec_loc;
                        is_tx_q <= dec_tx;
                        busy_q  <= sys_busy;
                        ndat_q  <= sys_busy ? '0 : dec_n;
                        cnt_q   <= '0;
                    end
                end
                ST_PTR_WAIT: ptr_q <= ram_rdata;
                ST_RX_DATA:  if (rx_valid) cnt_q <= cnt_q + CNT_W'(1);
                ST_TX_OUT:   cnt_q <= cnt_q + CNT_W'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        tx_valid  = 1'b0;
        tx_word   = '0;
        unique case (state_q)
            ST_PTR_RD: begin
                ram_en   = 1'b1;
                ram_addr = loc_q;
            end
            ST_CMD_WR: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = ptr_q[ADDR_W-1:0];
                ram_wdata = cmd_q;
            end
            ST_RX_DATA: begin
                ram_en    = rx_valid;
                ram_we    = rx_valid;
                ram_addr  = data_addr;
                ram_wdata = rx_word;
            end
            ST_TX_RD: begin
                ram_en   = 1'b1;
                ram_addr = data_addr;
            end
            ST_TX_OUT: begin
                tx_valid = 1'b1;
                tx_word  = ram_rdata;
            end
            ST_PTR_WR: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = loc_q;
                ram_wdata = ptr_upd;
            end
            default: ;
        endcase
    end

    // Pointer write-back only follows a clean end of message (R7)
    assert_wb_after_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR_WR) |-> $past(msg_ok))
        else $error("pointer written without msg_ok");

    // Live index decrements by one on write-back (R7)
    assert_idx_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR_WR && ptr_q[WORD_W-1:ADDR_W] != '0)
        |-> (ram_wdata[WORD_W-1:ADDR_W] == ptr_q[WORD_W-1:ADDR_W] - IDX_W'(1)))
        else $error("index not decremented");

    // Spent index leaves the pointer as read (R8)
    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR_WR && ptr_q[WORD_W-1:ADDR_W] == '0) |-> (ram_wdata == ptr_q))
        else $error("spent pointer modified");

    // Every transmit word comes from the read issued the cycle before (R5)
    assert_tx_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(ram_en && !ram_we))
        else $error("tx word without preceding read");

    // Busy commands move no data words (R9)
    assert_busy_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && (state_q == ST_RX_DATA || state_q == ST_TX_RD)) |-> !busy_q)
        else $error("data access under busy");

    // Abort leaves the RAM alone on the next cycle (R10)
    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_err && state_q != ST_IDLE && state_q != ST_PTR_WR) |=> !ram_en)
        else $error("RAM access after abort");

endmodule

// File: tb/msgbuf_mgr_tb_top.sv
module msgbuf_mgr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        sys_busy = 1'b0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_word = '0;
    logic        msg_ok = 1'b0;
    logic        msg_err = 1'b0;
    logic        ram_en, ram_we, tx_valid;
    logic [9:0]  ram_addr;
    logic [15:0] ram_wdata, tx_word;
    logic [15:0] ram_rdata = '0;

    logic [15:0] mem     [1024];
    logic [15:0] ref_mem [1024];
    logic [15:0] exp_tx [$];

    int checks = 0;
    int errors = 0;
    int seed = 1;

    always #2 clk = ~clk;

    msgbuf_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .sys_busy(sys_busy), .rx_valid(rx_valid), .rx_word(rx_word),
        .msg_ok(msg_ok), .msg_err(msg_err), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .tx_valid(tx_valid), .tx_word(tx_word)
    );

    // Behavioural shared RAM, one-cycle read latency
    always @(posedge clk) begin
        if (ram_en && ram_we)  mem[ram_addr] <= ram_wdata;
        if (ram_en && !ram_we) ram_rdata <= mem[ram_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Transmit stream compared against the model on every clock (R5)
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_tx.size() == 0) begin
                chk(1'b0, "R5 unexpected tx word", tx_word, 16'h0);
            end else begin
                logic [15:0] e;
                e = exp_tx.pop_front();
                chk(tx_word == e, "R5 tx word", tx_word, e);
            end
        end
    end

    task automatic compare_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 1024; i++) begin
            if (mem[i] !== ref_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (bad == 0) chk(1'b1, req, 16'h0, 16'h0);
        else chk(1'b0, $sformatf("%s mem[%h]", req, first), mem[first], ref_mem[first]);
    endtask

    task automatic poke(input int a, input logic [15:0] v);
        mem[a] = v;
        ref_mem[a] = v;
    endtask

    function automatic void decode_ref(input logic [15:0] c, output int loc, output int n, output bit tx);
        int sa;
        int f;
        sa = int'(c[9:5]);
        f = int'(c[4:0]);
        tx = c[10];
        loc = -1;
        n = 0;
        if (sa != 0 && sa != 31) begin
            loc = 'h3C0 + (tx ? 'h20 : 0) + sa;
            n = (f == 0) ? 32 : f;
        end else if (tx && f == 16) begin
            loc = 'h3C0; n = 1;
        end else if (!tx && f == 17) begin
            loc = 'h3DF; n = 1;
        end else if (tx && f == 18) begin
            loc = 'h3E0; n = 0;
        end else if (tx && f == 19) begin
            loc = 'h3FF; n = 1;
        end
    endfunction

    function automatic logic [15:0] mkcmd(input int tx, input int sa, input int f);
        return {5'd3, 1'(tx), 5'(sa), 5'(f)};
    endfunction

    task automatic run_msg(input logic [15:0] c, input bit busy, input bit fail, input string req);
        int loc, n, base, idx;
        bit tx;
        logic [15:0] p;
        decode_ref(c, loc, n, tx);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = c; sys_busy = busy;
        @(negedge clk);
        cmd_valid = 1'b0; sys_busy = 1'b0;
        if (loc < 0) begin
            repeat (8) @(negedge clk);
            compare_mem(req);
            return;
        end
        if (busy) n = 0;
        p = ref_mem[loc];
        base = int'(p[9:0]);
        idx = int'(p[15:10]);
        ref_mem[base] = c;
        if (tx) begin
            for (int i = 0; i < n; i++) exp_tx.push_back(ref_mem[(base + 1 + i) % 1024]);
        end
        repeat (4) @(negedge clk);
        if (!tx) begin
            for (int i = 0; i < n; i++) begin
                logic [15:0] w;
                w = 16'hA000 ^ 16'(seed * 37);
                seed++;
                rx_valid = 1'b1; rx_word = w;
                ref_mem[(base + 1 + i) % 1024] = w;
                @(negedge clk);
                rx_valid = 1'b0;
                @(negedge clk);
            end
        end else begin
            for (int k = 0; k < 200; k++) begin
                if (exp_tx.size() == 0) break;
                @(negedge clk);
            end
            chk(exp_tx.size() == 0, {req, " tx words delivered"}, 16'(exp_tx.size()), 16'h0);
            exp_tx.delete();
        end
        repeat (3) @(negedge clk);
        if (fail) msg_err = 1'b1; else msg_ok = 1'b1;
        @(negedge clk);
        msg_ok = 1'b0; msg_err = 1'b0;
        if (!fail && idx != 0) ref_mem[loc] = {6'(idx - 1), 10'((base + 1 + n) % 1024)};
        repeat (3) @(negedge clk);
        compare_mem(req);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) poke(i, 16'(i * 7) ^ 16'h5A5A);
        repeat (3) @(negedge clk);
        chk(ram_en == 1'b0 && tx_valid == 1'b0, "R1 during reset", {14'h0, ram_en, tx_valid}, 16'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ram_en == 1'b0 && tx_valid == 1'b0, "R1 after reset", {14'h0, ram_en, tx_valid}, 16'h0);

        // R2: boundary subaddresses
        poke('h3C1, {6'd5, 10'h020});
        run_msg(mkcmd(0, 1, 2), 0, 0, "R2 rx sa1");
        chk(mem['h3C1] == {6'd4, 10'h023}, "R2 rx sa1 pointer", mem['h3C1], {6'd4, 10'h023});
        poke('h3FE, {6'd1, 10'h050});
        run_msg(mkcmd(1, 30, 2), 0, 0, "R2 tx sa30");
        chk(mem['h3FE] == {6'd0, 10'h053}, "R2 tx sa30 pointer", mem['h3FE], {6'd0, 10'h053});

        // R4/R7/R8: three buffered receives then an overwrite
        poke('h3C4, {6'd2, 10'h080});
        run_msg(mkcmd(0, 4, 4), 0, 0, "R4 rx msg1");
        run_msg(mkcmd(0, 4, 2), 0, 0, "R7 rx msg2");
        run_msg(mkcmd(0, 4, 3), 0, 0, "R8 rx msg3 at zero index");
        chk(mem['h3C4] == {6'd0, 10'h088}, "R8 pointer frozen", mem['h3C4], {6'd0, 10'h088});
        run_msg(mkcmd(0, 4, 1), 0, 0, "R8 overwrite last buffer");

        // R5: transmit
        poke('h3F0, {6'd3, 10'h100});
        run_msg(mkcmd(1, 16, 3), 0, 0, "R5 tx sa16 a");
        run_msg(mkcmd(1, 16, 2), 0, 0, "R5 tx sa16 b");

        // R6: count field zero, with address wrap on receive
        poke('h3DE, {6'd1, 10'h3F0});
        run_msg(mkcmd(0, 30, 0), 0, 0, "R6 rx 32 words wrap");
        chk(mem['h3DE] == {6'd0, 10'h011}, "R6 rx pointer", mem['h3DE], {6'd0, 10'h011});
        poke('h3E2, {6'd1, 10'h300});
        run_msg(mkcmd(1, 2, 0), 0, 0, "R6 tx 32 words");

        // R3: mode codes
        poke('h3C0, {6'd1, 10'h180});
        run_msg(mkcmd(1, 0, 16), 0, 0, "R3 vector word");
        poke('h3DF, {6'd1, 10'h190});
        run_msg(mkcmd(0, 31, 17), 0, 0, "R3 sync with data");
        poke('h3FF, {6'd1, 10'h1A0});
        run_msg(mkcmd(1, 31, 19), 0, 0, "R3 bit word");
        run_msg(mkcmd(1, 0, 2), 0, 0, "R3 unmapped mode code");
        run_msg(mkcmd(0, 0, 16), 0, 0, "R3 receive code16 unmapped");

        // R9: busy
        poke('h3C5, {6'd4, 10'h1B0});
        run_msg(mkcmd(0, 5, 4), 1, 0, "R9 busy rx");
        chk(mem['h3C5] == {6'd3, 10'h1B1}, "R9 busy rx pointer", mem['h3C5], {6'd3, 10'h1B1});
        poke('h3E6, {6'd2, 10'h1C0});
        run_msg(mkcmd(1, 6, 2), 1, 0, "R9 busy tx");

        // R10: aborts
        poke('h3C7, {6'd3, 10'h1D0});
        run_msg(mkcmd(0, 7, 3), 0, 1, "R10 rx abort");
        chk(mem['h3C7] == {6'd3, 10'h1D0}, "R10 pointer kept", mem['h3C7], {6'd3, 10'h1D0});
        poke('h3E8, {6'd2, 10'h1E0});
        run_msg(mkcmd(1, 8, 2), 0, 1, "R10 tx abort");

        // R11: last-command chain
        poke('h3E0, 16'hFC00);
        for (int i = 0; i < 64; i++) begin
            run_msg({5'(i), 1'b1, 5'd0, 5'd18}, 0, 0, "R11 last command store");
            if (i == 0)  chk(mem['h3E0] == 16'hF801, "R11 after first", mem['h3E0], 16'hF801);
            if (i == 62) chk(mem['h3E0] == 16'h003F, "R11 after 63rd", mem['h3E0], 16'h003F);
        end
        chk(mem['h3E0] == 16'h003F, "R11 held after 64th", mem['h3E0], 16'h003F);
        chk(mem['h03F] == {5'd31, 1'b1, 5'd0, 5'd18}, "R11 last buffer overwritten",
            mem['h03F], {5'd31, 1'b1, 5'd0, 5'd18});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule